// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Error Abort

This block collects the completion and failure events of a five-channel DMA engine and turns them into one interrupt line. Each channel can raise three kinds of event: its whole transfer finished, one block finished reaching the destination, or the bus answered one of its accesses with an error response. Every event pulse sets a raw status bit. A per-kind mask selects which raw bits count towards the interrupt. Software reads raw or masked status and acknowledges events by writing ones into a clear register.

A bus error response does more than flag an interrupt. It cancels the transfer by dropping the enable of the channel that owned the failing access. The enable stays low until software writes it high again. All registers sit behind a simple word-addressed write/read port. The address splits into a 2-bit group in bits [3:2] and a 2-bit slot in bits [1:0]. Groups are raw = 0, masked = 1, mask = 2 and clear = 3. Slots are transfer = 0, block = 1 and error = 2. Slot 3 of the mask group holds the channel enables, one bit per channel, with bit i for channel i.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A pulse on a channel's transfer-done, block-done or error event sets that channel's raw bit of the matching kind at the next clock edge, whatever the mask holds.
- R2: Each kind's masked status equals its raw bits ANDed with that kind's mask register. Writing the mask group, slot 0 to 2, loads the mask.
- R3: `irq_o` is the OR of all fifteen masked status bits, registered, so it follows a status or mask change by one clock.
- R4: Writing the clear group, slot 0 to 2, clears each raw bit of that kind whose data bit is 1. Bits written with 0 keep their value.
- R5: When an event and a clear hit the same raw bit in the same cycle, the bit ends up set.
- R6: `bus_err_i` with `err_ch_i` below the channel count sets that channel's raw error bit and clears its enable, even when software writes that enable in the same cycle.
- R7: Writing address 0xB loads the channel enables, which drive `ch_en_o`. An enable cleared by an error abort stays cleared until software writes it.
- R8: A read returns data one clock after `reg_rd_i`. The clear group, slot 3 of the raw and masked groups, and any address with bits above [3:0] set all read as zero.
- R9: After reset all raw bits, masks, enables, `irq_o` and `reg_rdata_o` are zero.
- R10: `bus_err_i` with an `err_ch_i` value at or above the channel count changes neither status nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tfr_i | input | NUM_CH | Transfer-complete pulse, one bit per channel |
| ev_blk_i | input | NUM_CH | Block-complete pulse, one bit per channel |
| bus_err_i | input | 1 | Error response seen on the bus for the current access |
| err_ch_i | input | CH_W | Channel that owned the failing access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | NUM_CH | Write data, one bit per channel |
| reg_rdata_o | output | NUM_CH | Registered read data |
| irq_o | output | 1 | Combined interrupt line |
| ch_en_o | output | NUM_CH | Channel enables |

## Verification
The bench builds the block with its defaults: five channels and a 4-bit address. At that size every event kind can be pulsed on every channel, all 32 mask patterns can be swept for each kind, and every address can be read after each step. Expected raw, masked and enable values come from a small bench model. The 3-bit channel field also leaves codes 5 to 7 free, so out-of-range error reports can be driven. Same-cycle races are forced on purpose: event against clear, and error abort against an enable write.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int NUM_KIND = 3;

  typedef enum logic [1:0] {
    EV_TFR = 2'd0,
    EV_BLK = 2'd1,
    EV_ERR = 2'd2
  } ev_kind_e;

  typedef enum logic [1:0] {
    GRP_RAW  = 2'd0,
    GRP_STAT = 2'd1,
    GRP_MASK = 2'd2,
    GRP_CLR  = 2'd3
  } reg_grp_e;

  localparam logic [1:0] SLOT_CHEN = 2'd3;

endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_i,
  input  logic              mask_wr_i,
  input  logic              clr_wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] stat_o
);

  logic [NUM_CH-1:0] raw_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] clr_bits;

  assign clr_bits = clr_wr_i ? wdata_i : '0;

  // Event set wins over clear on the same bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | ev_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (mask_wr_i) begin
      mask_q <= wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign stat_o = raw_q & mask_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_event_sets_R1: assert property (@(posedge clk) disable iff (rst)
      ev_i[i] |=> raw_q[i]);
    assert_clear_one_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_wr_i && wdata_i[i] && !ev_i[i]) |=> !raw_q[i]);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!ev_i[i] && !(clr_wr_i && wdata_i[i])) |=> $stable(raw_q[i]));
    assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (ev_i[i] && clr_wr_i && wdata_i[i]) |=> raw_q[i]);
  end

endmodule

// File: rtl/dma_irq_chen.sv
module dma_irq_chen #(
  parameter int NUM_CH = 5,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic              err_vld_i,
  input  logic [CH_W-1:0]   err_ch_i,
  output logic [NUM_CH-1:0] err_hit_o,
  output logic [NUM_CH-1:0] en_o
);

  logic [NUM_CH-1:0] err_hit;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] en_nxt;

  // Decode of the failing channel; codes at or above NUM_CH match nothing.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign err_hit[i] = err_vld_i && (err_ch_i == CH_W'(i));
  end

  always_comb begin
    en_nxt = en_wr_i ? wdata_i : en_q;
    en_nxt = en_nxt & ~err_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      en_q <= en_nxt;
    end
  end

  assign err_hit_o = err_hit;
  assign en_o      = en_q;

  always_comb begin
    assert_one_abort_R6: assert ($onehot0(err_hit));
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_abort_clears_R6: assert property (@(posedge clk) disable iff (rst)
      err_hit[i] |=> !en_q[i]);
    assert_no_self_enable_R7: assert property (@(posedge clk) disable iff (rst)
      (!en_wr_i && !err_hit[i]) |=> $stable(en_q[i]));
  end

endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             reg_wr_i,
  input  logic                             reg_rd_i,
  input  logic [ADDR_W-1:0]                reg_addr_i,
  input  logic [NUM_KIND-1:0][NUM_CH-1:0]  raw_i,
  input  logic [NUM_KIND-1:0][NUM_CH-1:0]  stat_i,
  input  logic [NUM_KIND-1:0][NUM_CH-1:0]  mask_i,
  input  logic [NUM_CH-1:0]                en_i,
  output logic [NUM_KIND-1:0]              mask_wr_o,
  output logic [NUM_KIND-1:0]              clr_wr_o,
  output logic                             en_wr_o,
  output logic [NUM_CH-1:0]                rdata_o
);

  logic       in_map;
  reg_grp_e   grp;
  logic [1:0] slot;
  logic [NUM_CH-1:0] rd_word;
  logic [NUM_CH-1:0] rdata_q;

  if (ADDR_W > 4) begin : g_hi
    assign in_map = ~|reg_addr_i[ADDR_W-1:4];
  end else begin : g_nohi
    assign in_map = 1'b1;
  end

  assign grp  = reg_grp_e'(reg_addr_i[3:2]);
  assign slot = reg_addr_i[1:0];

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_wdec
    assign mask_wr_o[k] = reg_wr_i && in_map && (grp == GRP_MASK) && (slot == 2'(k));
    assign clr_wr_o[k]  = reg_wr_i && in_map && (grp == GRP_CLR)  && (slot == 2'(k));
  end
  assign en_wr_o = reg_wr_i && in_map && (grp == GRP_MASK) && (slot == SLOT_CHEN);

  always_comb begin
    rd_word = '0;
    if (in_map) begin
      for (int k = 0; k < NUM_KIND; k++) begin
        if (slot == 2'(k)) begin
          case (grp)
            GRP_RAW:  rd_word = raw_i[k];
            GRP_STAT: rd_word = stat_i[k];
            GRP_MASK: rd_word = mask_i[k];
            default:  rd_word = '0;
          endcase
        end
      end
      if (grp == GRP_MASK && slot == SLOT_CHEN) begin
        rd_word = en_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      rdata_q <= rd_word;
    end
  end

  assign rdata_o = rdata_q;

  assert_clr_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && grp == GRP_CLR) |=> (rdata_q == '0));
  assert_rdata_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> $stable(rdata_q));
  always_comb begin
    assert_single_write_target_R8: assert ($onehot0({mask_wr_o, clr_wr_o, en_wr_o}));
  end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter  int NUM_CH = 5,
  parameter  int ADDR_W = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_tfr_i,
  input  logic [NUM_CH-1:0] ev_blk_i,
  input  logic              bus_err_i,
  input  logic [CH_W-1:0]   err_ch_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_CH-1:0] reg_wdata_i,
  output logic [NUM_CH-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [NUM_CH-1:0] ch_en_o
);

  logic [NUM_KIND-1:0][NUM_CH-1:0] ev_vec;
  logic [NUM_KIND-1:0][NUM_CH-1:0] raw;
  logic [NUM_KIND-1:0][NUM_CH-1:0] stat;
  logic [NUM_KIND-1:0][NUM_CH-1:0] mask;
  logic [NUM_KIND-1:0]             mask_wr;
  logic [NUM_KIND-1:0]             clr_wr;
  logic                            en_wr;
  logic [NUM_CH-1:0]               err_hit;
  logic [NUM_CH-1:0]               en;
  logic                            irq_q;

  assign ev_vec[EV_TFR] = ev_tfr_i;
  assign ev_vec[EV_BLK] = ev_blk_i;
  assign ev_vec[EV_ERR] = err_hit;

  dma_irq_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_addr_i (reg_addr_i),
    .raw_i      (raw),
    .stat_i     (stat),
    .mask_i     (mask),
    .en_i       (en),
    .mask_wr_o  (mask_wr),
    .clr_wr_o   (clr_wr),
    .en_wr_o    (en_wr),
    .rdata_o    (reg_rdata_o)
  );

  dma_irq_chen #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chen (
    .clk       (clk),
    .rst       (rst),
    .en_wr_i   (en_wr),
    .wdata_i   (reg_wdata_i),
    .err_vld_i (bus_err_i),
    .err_ch_i  (err_ch_i),
    .err_hit_o (err_hit),
    .en_o      (en)
  );

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    dma_irq_status #(.NUM_CH(NUM_CH)) u_status (
      .clk       (clk),
      .rst       (rst),
      .ev_i      (ev_vec[k]),
      .mask_wr_i (mask_wr[k]),
      .clr_wr_i  (clr_wr[k]),
      .wdata_i   (reg_wdata_i),
      .raw_o     (raw[k]),
      .mask_o    (mask[k]),
      .stat_o    (stat[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |stat;
    end
  end

  assign irq_o   = irq_q;
  assign ch_en_o = en;

  assert_irq_rises_R3: assert property (@(posedge clk) disable iff (rst)
    (|stat) |=> irq_q);
  assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !(|stat) |=> !irq_q);
  assert_err_raw_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_err_i && err_ch_i < CH_W'(NUM_CH)) |=> (|raw[EV_ERR]));

endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;

  localparam int NCH = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ev_tfr = '0;
  logic [NCH-1:0] ev_blk = '0;
  logic           bus_err = 1'b0;
  logic [2:0]     err_ch = '0;
  logic           reg_wr = 1'b0;
  logic           reg_rd = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [NCH-1:0] reg_wdata = '0;
  logic [NCH-1:0] reg_rdata;
  logic           irq;
  logic [NCH-1:0] ch_en;

  int n_chk = 0;
  int n_fail = 0;

  logic [NCH-1:0] m_raw [3];
  logic [NCH-1:0] m_mask [3];
  logic [NCH-1:0] m_en;

  always #4 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH), .ADDR_W(4)) u_dma_irq_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ev_tfr_i    (ev_tfr),
    .ev_blk_i    (ev_blk),
    .bus_err_i   (bus_err),
    .err_ch_i    (err_ch),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq),
    .ch_en_o     (ch_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NCH-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NCH-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  function automatic logic [NCH-1:0] exp_word(input logic [3:0] a);
    int s = int'(a[1:0]);
    case (a[3:2])
      2'd0: return (s < 3) ? m_raw[s] : '0;
      2'd1: return (s < 3) ? (m_raw[s] & m_mask[s]) : '0;
      2'd2: return (s < 3) ? m_mask[s] : m_en;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int k = 0; k < 3; k++) r = r | (|(m_raw[k] & m_mask[k]));
    return r;
  endfunction

  task automatic verify_all(input string tag);
    logic [NCH-1:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      case (a / 4)
        0: chk({tag, " R1 raw"}, 32'(d), 32'(exp_word(4'(a))));
        1: chk({tag, " R2 masked"}, 32'(d), 32'(exp_word(4'(a))));
        2: chk({tag, (a == 11) ? " R7 enable" : " R2 mask"}, 32'(d), 32'(exp_word(4'(a))));
        default: chk({tag, " R8 clear reads zero"}, 32'(d), 32'(exp_word(4'(a))));
      endcase
    end
    chk({tag, " R3 irq"}, 32'(irq), 32'(exp_irq()));
    chk({tag, " R6 ch_en"}, 32'(ch_en), 32'(m_en));
  endtask

  task automatic pulse(input int kind, input int ch);
    @(negedge clk);
    if (kind == 0) ev_tfr[ch] = 1'b1;
    else if (kind == 1) ev_blk[ch] = 1'b1;
    else begin bus_err = 1'b1; err_ch = 3'(ch); end
    @(posedge clk);
    @(negedge clk);
    ev_tfr = '0; ev_blk = '0; bus_err = 1'b0;
    if (ch < NCH) begin
      m_raw[kind][ch] = 1'b1;
      if (kind == 2) m_en[ch] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NCH-1:0] d;
    for (int k = 0; k < 3; k++) begin m_raw[k] = '0; m_mask[k] = '0; end
    m_en = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9 irq after reset", 32'(irq), 0);
    chk("R9 ch_en after reset", 32'(ch_en), 0);
    chk("R9 rdata after reset", 32'(reg_rdata), 0);
    verify_all("R9");

    // R7: software enables all channels
    wr(4'hB, 5'h1F); m_en = 5'h1F;
    chk("R7 enable write", 32'(ch_en), 32'h1F);

    // R1: every event on every channel latches with masks at zero
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < NCH; c++) begin
        pulse(k, c);
        chk("R1 raw after pulse", 32'(exp_word(4'(k))), 32'(m_raw[k]));
        verify_all("R1 sweep");
      end
    end
    chk("R1 irq stays low with masks zero", 32'(irq), 0);

    // R2/R3: full mask sweep per kind with all raw bits set
    for (int k = 0; k < 3; k++) begin
      for (int m = 0; m < 32; m++) begin
        wr(4'(8 + k), 5'(m)); m_mask[k] = 5'(m);
        rd(4'(4 + k), d);
        chk("R2 masked sweep", 32'(d), 32'(5'(m) & m_raw[k]));
        chk("R3 irq sweep", 32'(irq), 32'(exp_irq()));
      end
      wr(4'(8 + k), 5'h00); m_mask[k] = '0;
    end

    // R3: irq latency is one clock after the mask write takes effect
    wr(4'h9, 5'h04); m_mask[1] = 5'h04;
    chk("R3 irq before latency", 32'(irq), 0);
    @(posedge clk); @(negedge clk);
    chk("R3 irq after latency", 32'(irq), 1);

    // R4: zero-write has no effect, one-write clears only its bit
    wr(4'hD, 5'h00);
    verify_all("R4 zero clear");
    wr(4'hD, 5'h04); m_raw[1][2] = 1'b0;
    verify_all("R4 single clear");
    chk("R4 irq drops after clear", 32'(irq), 0);
    wr(4'hC, 5'h1F); m_raw[0] = '0;
    wr(4'hE, 5'h1F); m_raw[2] = '0;
    verify_all("R4 full clear");

    // R5: event and clear on the same cycle
    m_raw[0] = 5'h08;
    pulse(0, 3);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'hC; reg_wdata = 5'h0C; ev_tfr[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; ev_tfr = '0;
    m_raw[0] = 5'h04;
    verify_all("R5 event beats clear");

    // R10: out-of-range error channel codes
    wr(4'hB, 5'h1F); m_en = 5'h1F;
    for (int c = NCH; c < 8; c++) begin
      pulse(2, c);
      verify_all("R10 out of range");
    end

    // R6: abort wins over a same-cycle enable write
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'hB; reg_wdata = 5'h1F; bus_err = 1'b1; err_ch = 3'd4;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; bus_err = 1'b0;
    m_raw[2][4] = 1'b1; m_en[4] = 1'b0;
    chk("R6 abort beats enable write", 32'(ch_en), 32'h0F);
    verify_all("R6 abort");

    // R7: no self re-enable, then software re-enable
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R7 stays disabled", 32'(ch_en[4]), 0);
    wr(4'hB, 5'h1F); m_en = 5'h1F;
    chk("R7 software re-enable", 32'(ch_en), 32'h1F);
    wr(4'hA, 5'h10); m_mask[2] = 5'h10;
    @(posedge clk); @(negedge clk);
    chk("R3 error irq", 32'(irq), 1);
    verify_all("R7 final");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule